// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block holds three byte-wide control registers. From them it decides, for each access to the legacy upper-memory window C0000h to FFFFFh, whether the access goes to on-board DRAM or out to the external bus. The window is split into two sizes of segment. Eight 16 KB segments cover C0000h to DFFFFh. Two 64 KB segments cover E0000h to EFFFFh and F0000h to FFFFFh. Every segment carries its own 2-bit routing code, so read routing and write routing are chosen separately.

Software programs the registers through a simple write port: a select, a data byte and a strobe. It reads them back through a separate select. The memory side presents a 20-bit lookup address and a flag that marks the access as a write. The decision comes back combinationally, worked out from the stored register values. Two status flags report whether any part of the BIOS area (E0000h to FFFFFh) is shadowed for reads or for writes.

Top module: `shadow_route_decoder`

## Requirements
- R1: After reset all three control registers read 0, every segment routes both reads and writes to the external bus (`look_dram` = 0), and both BIOS flags are 0.
- R2: Selects 0, 1 and 2 read back exactly the byte last written there. Select 3 reads 0x00, and a write to select 3 changes no register.
- R3: A register write takes effect on the clock edge that samples the strobe. A lookup made in the same cycle as the write still uses the old value.
- R4: Register 0 routes the 16 KB segments C0000h, C4000h, C8000h and CC000h. Their codes sit in bits 1:0, 3:2, 5:4 and 7:6 in that order.
- R5: Register 1 routes the 16 KB segments D0000h, D4000h, D8000h and DC000h, laid out in the same bit order as register 0.
- R6: In register 2, bits 7:6 route the 64 KB segment at E0000h and bits 5:4 route the 64 KB segment at F0000h. Bits 3:0 have no effect on routing or on the flags.
- R7: Code bit 1 sends reads to DRAM and code bit 0 sends writes to DRAM. So code 0 sends everything external, 1 sends only writes to DRAM, 2 sends only reads to DRAM, and 3 sends everything to DRAM.
- R8: For an address below C0000h, `look_dram` is 0 whatever the registers hold.
- R9: `bios_shadow_rd` is the OR of code bit 1 of the E0000h and F0000h segments. `bios_shadow_wr` is the OR of code bit 0 of those same two segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register index for the write (0 to 2; 3 is unused) |
| cfg_wr_data | input | 8 | Byte to write |
| cfg_rd_sel | input | 2 | Register index for readback |
| cfg_rd_data | output | 8 | Readback byte (0 for index 3) |
| look_addr | input | 20 | Memory access address |
| look_write | input | 1 | 1 for a write access, 0 for a read |
| look_dram | output | 1 | 1 when the access goes to DRAM |
| bios_shadow_rd | output | 1 | BIOS area read-shadow flag |
| bios_shadow_wr | output | 1 | BIOS area write-shadow flag |

## Verification
Register 0 is loaded with a different code in each field, so a lookup in each 16 KB segment shows both that the field order is right and that the four code meanings are told apart. Register 1 gets the fields in reverse, which catches a swap between the two small-segment registers. Register 2 is tried with only its low nibble set, then with a different code in E and in F. This separates the E and F fields from each other and shows that the low nibble has no effect. A random run follows: it writes to any select, and its lookups include addresses below the window and at the segment edges. A behavioural model in the bench checks every cycle of it.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int ADDR_W  = 20;
  localparam int REG_W   = 8;
  localparam int NUM_REGS = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    RT_EXT_ALL   = 2'd0,
    RT_WR_DRAM   = 2'd1,
    RT_RD_DRAM   = 2'd2,
    RT_DRAM_ALL  = 2'd3
  } route_code_e;

  // bit 1 of a code selects DRAM for reads, bit 0 for writes
  function automatic logic code_to_dram(input logic [1:0] code, input logic is_wr);
    return is_wr ? code[0] : code[1];
  endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int N_REGS = NUM_REGS,
  parameter int RW     = REG_W,
  parameter int SW     = SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SW-1:0]               wr_sel,
  input  logic [RW-1:0]               wr_data,
  input  logic [SW-1:0]               rd_sel,
  output logic [RW-1:0]               rd_data,
  output logic [N_REGS-1:0][RW-1:0]   ctl_q
);
  logic wr_hit;
  assign wr_hit = wr_en && (int'(wr_sel) < N_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_hit) ctl_q[wr_sel] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++)
      if (int'(rd_sel) == i) rd_data = ctl_q[i];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rd_sel != $past(wr_sel) || rd_data == $past(wr_data)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q)); // R2
  AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) >= N_REGS) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup
  import shadow_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REG_W
) (
  input  logic [2:0][RW-1:0] ctl,
  input  logic [AW-1:0]      addr,
  input  logic               is_wr,
  output logic               in_window,
  output logic [1:0]         seg_code,
  output logic               dram
);
  localparam int SMALL_SEGS = 8;
  localparam int PER_REG    = RW / 2;

  logic [1:0] small_code [SMALL_SEGS];

  for (genvar g = 0; g < SMALL_SEGS; g++) begin : g_small
    assign small_code[g] = ctl[g / PER_REG][(g % PER_REG) * 2 +: 2];
  end

  // window C0000h..FFFFFh: top two address bits set
  assign in_window = &addr[AW-1:AW-2];

  always_comb begin
    if (!addr[AW-3])       seg_code = small_code[addr[AW-4:AW-6]];
    else if (!addr[AW-4])  seg_code = ctl[2][7:6];
    else                   seg_code = ctl[2][5:4];
  end

  assign dram = in_window && code_to_dram(seg_code, is_wr);

  always_comb begin
    if (in_window && seg_code == RT_EXT_ALL)
      AST_CODE0_EXTERNAL: assert (!dram); // R7
    if (in_window && seg_code == RT_DRAM_ALL)
      AST_CODE3_DRAM: assert (dram); // R7
  end
endmodule

// File: rtl/shadow_bios_flags.sv
module shadow_bios_flags
  import shadow_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] ctl_hi,
  output logic          shadow_rd,
  output logic          shadow_wr
);
  logic [1:0] e_code, f_code;
  assign e_code = ctl_hi[7:6];
  assign f_code = ctl_hi[5:4];

  assign shadow_rd = code_to_dram(e_code, 1'b0) | code_to_dram(f_code, 1'b0);
  assign shadow_wr = code_to_dram(e_code, 1'b1) | code_to_dram(f_code, 1'b1);

  always_comb begin
    if (ctl_hi[7:4] == 4'h0)
      AST_FLAGS_IDLE: assert (!shadow_rd && !shadow_wr); // R9
  end
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              look_write,
  output logic              look_dram,
  output logic              bios_shadow_rd,
  output logic              bios_shadow_wr
);
  logic [NUM_REGS-1:0][REG_W-1:0] ctl_q;
  logic       in_window;
  logic [1:0] seg_code;

  shadow_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .ctl_q(ctl_q)
  );

  shadow_seg_lookup u_lookup (
    .ctl(ctl_q), .addr(look_addr), .is_wr(look_write),
    .in_window(in_window), .seg_code(seg_code), .dram(look_dram)
  );

  shadow_bios_flags u_flags (
    .ctl_hi(ctl_q[2]), .shadow_rd(bios_shadow_rd), .shadow_wr(bios_shadow_wr)
  );

  AST_OUTSIDE_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (look_addr[ADDR_W-1:ADDR_W-2] != 2'b11) |-> !look_dram); // R8
  AST_WINDOW_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> !look_dram); // R8
endmodule

// File: tb/tb_shadow_route_decoder.sv
module tb_shadow_route_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = '0;
  logic [7:0] cfg_wr_data = '0;
  logic [1:0] cfg_rd_sel = '0;
  logic [7:0] cfg_rd_data;
  logic [19:0] look_addr = '0;
  logic look_write = 1'b0;
  logic look_dram, bios_shadow_rd, bios_shadow_wr;

  int checks = 0;
  int errors = 0;
  int model [3];

  always #4 clk = ~clk;

  shadow_route_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .look_addr(look_addr), .look_write(look_write), .look_dram(look_dram),
    .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr)
  );

  function automatic int code_at(int a);
    int idx;
    if (a < 'hC0000) return -1;
    if (a < 'hE0000) begin
      idx = (a - 'hC0000) / 'h4000;
      return (model[idx / 4] >> (2 * (idx % 4))) & 3;
    end
    if (a < 'hF0000) return (model[2] >> 6) & 3;
    return (model[2] >> 4) & 3;
  endfunction

  function automatic bit exp_dram(int a, bit w);
    int c = code_at(a);
    if (c < 0) return 1'b0;
    return w ? (c % 2 == 1) : (c >= 2);
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h addr=%05h", tag, what, act, exp, look_addr);
    end
  endtask

  task automatic step(bit we, int ws, int wd, int rs, int a, bit w, string tag);
    int ec, fc;
    @(negedge clk);
    cfg_wr_en = we; cfg_wr_sel = 2'(ws); cfg_wr_data = 8'(wd);
    cfg_rd_sel = 2'(rs); look_addr = 20'(a); look_write = w;
    #1;
    ec = (model[2] >> 6) & 3; fc = (model[2] >> 4) & 3;
    chk(tag, look_dram, exp_dram(a, w), "look_dram");
    chk(tag, cfg_rd_data, (rs < 3) ? model[rs] : 0, "cfg_rd_data");
    chk(tag, bios_shadow_rd, (ec >= 2 || fc >= 2) ? 1 : 0, "bios_shadow_rd");
    chk(tag, bios_shadow_wr, (ec % 2 == 1 || fc % 2 == 1) ? 1 : 0, "bios_shadow_wr");
    @(posedge clk);
    if (we && ws < 3) model[ws] = wd;
  endtask

  task automatic probe_both(int a, string tag);
    step(0, 0, 0, 0, a, 0, tag);
    step(0, 0, 0, 0, a, 1, tag);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 3; s++) step(0, 0, 0, s, 'hC0000 + s * 'h10000, s[0], "R1");
    for (int a = 'hC0000; a <= 'hFC000; a += 'h4000) step(0, 0, 0, 0, a, a[14], "R1");

    // R4 and R7: distinct code per small field of register 0
    step(1, 0, 'hE4, 0, 'hC0000, 0, "R3");
    probe_both('hC0000, "R4_R7");
    probe_both('hC4000, "R4_R7");
    probe_both('hC8000, "R4_R7");
    probe_both('hCFFFF, "R4_R7");

    // R3: same-cycle lookup uses old value, next cycle new value
    step(1, 1, 'hFF, 1, 'hD0000, 0, "R3");
    step(0, 0, 0, 1, 'hD0000, 0, "R3");

    // R5: register 1 reversed fields
    step(1, 1, 'h1B, 1, 'hD0000, 0, "R5");
    probe_both('hD0000, "R5");
    probe_both('hD4000, "R5");
    probe_both('hD8000, "R5");
    probe_both('hDFFFF, "R5");

    // R6: low nibble of register 2 has no effect
    step(1, 2, 'h0F, 2, 'hE0000, 0, "R6");
    probe_both('hE0000, "R6");
    probe_both('hF0000, "R6");

    // R6 and R9: E code 2, F code 1
    step(1, 2, 'h90, 2, 'hEFFFF, 0, "R9");
    probe_both('hE8000, "R6_R9");
    probe_both('hF8000, "R6_R9");
    step(1, 2, 'h40, 2, 'hE0000, 1, "R9");
    probe_both('hF0000, "R9");

    // R2: select 3 write ignored, readback of every select
    step(1, 3, 'hAA, 3, 'hC0000, 0, "R2");
    for (int s = 0; s < 4; s++) step(0, 0, 0, s, 'hC0000, 0, "R2");

    // R8: all codes 3, addresses below window
    step(1, 0, 'hFF, 0, 0, 0, "R8");
    step(1, 1, 'hFF, 1, 0, 0, "R8");
    step(1, 2, 'hFF, 2, 0, 0, "R8");
    probe_both('h00000, "R8");
    probe_both('hBFFFF, "R8");
    probe_both('h9ABCD, "R8");
    probe_both('hC0000, "R8");
    probe_both('hFFFFF, "R8");

    // random mix checked against model each cycle
    for (int n = 0; n < 600; n++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 'hC0000) : int'('hC0000 + $urandom % 'h40000);
      step($urandom % 3 == 0, $urandom % 4, $urandom % 256, $urandom % 4, a,
           $urandom % 2, "R7_rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule